// File: doc/BRIEF.md
# Hyperspectral Pixel Stream Sequencer

This block feeds a bank of skewer projection units from an input FIFO that a block-transfer engine keeps topped up. A pass starts with a `start` pulse, which latches the pixel count and the band count. The sequencer then takes the first two FIFO words as the random-generator seeds. After that it streams band samples, one per clock. Each sample goes to the projection units together with an advance strobe for the skewer-bit generator.

After the last band of every pixel, the sequencer inserts one compare cycle. In that cycle the projection units update their running minimum and maximum, and the generator restores its seeds. A stall on an empty FIFO freezes all progress. While a pass is feeding, the sequencer asks the transfer engine for a half-FIFO block whenever occupancy falls to half capacity or lower. It keeps at most one such request outstanding.

Once the last pixel has been compared, the sequencer walks the projection units' extreme-pixel indices into an output FIFO, one word per clock. It then pulses `done`.

Top module: `hsi_feed_sequencer`

## Requirements
- R1: During and right after a synchronous active-low reset, every strobe is low: `in_rd_en`, `seed_load`, `gen_advance`, `gen_restore`, `band_valid`, `px_end`, `out_wr`, `refill_req` and `done`.
- R2: `start` in the idle state latches `cfg_pixels` and `cfg_bands`, both at least 1. A `start` pulse or a configuration change while a pass runs has no effect on that pass.
- R3: The first two words read after `start` are given to the generator. Each is marked by `seed_load`, with `seed_sel` = 0 for the first and 1 for the second, and `seed_data` carries the word.
- R4: In the band phase, every cycle that `in_empty` is low reads one word (`in_rd_en`) and presents it on `band_data` with `band_valid` and `gen_advance` high. No band is presented before pixel data is present in the FIFO.
- R5: While the FIFO is empty, no word is read and `band_valid` and `gen_advance` stay low. Streaming resumes at the same band position once data arrives.
- R6: After exactly `cfg_bands` samples of a pixel, one cycle carries `px_end` and `gen_restore` with `px_index` equal to the 0-based pixel number. No word is read in that cycle.
- R7: During the seed, band and compare phases, `refill_req` pulses for one cycle when `in_level` ≤ DEPTH/2 and no request is outstanding. `refill_len` always equals DEPTH/2.
- R8: After a request, no further request is issued until `refill_done` has been seen. The sequencer is re-armed from the following cycle.
- R9: After the last pixel's compare cycle, `out_wr` is high for 2·NSKEW consecutive cycles. `res_sel` counts 0 upward in those cycles, and `out_data` equals `res_word`.
- R10: `done` pulses for one cycle right after the last result write. The sequencer then returns to idle and accepts a new `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a pass (taken only when idle) |
| cfg_pixels | input | PIX_W | Pixels in the image |
| cfg_bands | input | BAND_W | Band samples per pixel |
| in_data | input | DATA_W | Head word of the input FIFO (first-word fall-through) |
| in_empty | input | 1 | Input FIFO empty |
| in_level | input | LVL_W | Input FIFO occupancy |
| in_rd_en | output | 1 | Pop the input FIFO head |
| refill_req | output | 1 | One-cycle request for a block transfer |
| refill_len | output | LVL_W | Words per requested block (DEPTH/2) |
| refill_done | input | 1 | Requested block fully written |
| seed_load | output | 1 | Seed word valid for the generator |
| seed_sel | output | 1 | Which seed (0 first, 1 second) |
| seed_data | output | DATA_W | Seed word |
| gen_advance | output | 1 | Generator steps to next skewer bits |
| gen_restore | output | 1 | Generator reloads its seeds |
| band_valid | output | 1 | Band sample valid for accumulation |
| band_data | output | DATA_W | Band sample |
| px_end | output | 1 | Compare/update cycle for the current pixel |
| px_index | output | PIX_W | Current pixel number |
| res_sel | output | RSEL_W | Result word selector into the array |
| res_word | input | PIX_W | Selected extreme-pixel index from the array |
| out_wr | output | 1 | Output FIFO write |
| out_data | output | PIX_W | Output FIFO write data |
| done | output | 1 | Pass finished |

## Verification
The refill watermark is judged on its own, apart from the phase machine, so a request can land in the same cycle as a seed load, a band read or a compare cycle. The bench provokes this with small FIFO depths and with preloads both below and above half capacity, so occupancy crosses the watermark at many phase positions. A slow feeder mode empties the FIFO in mid-pixel, so a stall also meets an outstanding refill. The behavioural model predicts each cycle's strobes and its request independently, from its own phase counters and the occupancy it sees, and compares every output on every clock.

// File: rtl/hsi_seq_pkg.sv
// Shared types for the pixel stream sequencer.
package hsi_seq_pkg;
    // Pass phases, in the order a pass walks through them.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_SEED = 3'd1,
        PH_BAND = 3'd2,
        PH_CMP  = 3'd3,
        PH_DUMP = 3'd4,
        PH_FIN  = 3'd5
    } seq_phase_t;
endpackage

// File: rtl/seq_phase_ctl.sv
// Pass phase machine: seed fetch, band streaming with stalls, per-pixel
// compare cycle, result walk and finish. Assumes a first-word fall-through
// input FIFO and that the latched counts are at least 1.
module seq_phase_ctl
    import hsi_seq_pkg::*;
#(
    parameter int PIX_W  = 20,
    parameter int BAND_W = 10,
    parameter int NRES   = 40,
    parameter int RSEL_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIX_W-1:0]  cfg_pixels,
    input  logic [BAND_W-1:0] cfg_bands,
    input  logic              in_empty,
    output seq_phase_t        phase,
    output logic              seed_idx,
    output logic [PIX_W-1:0]  pix_cnt,
    output logic [RSEL_W-1:0] dump_cnt
);
    logic [PIX_W-1:0]  np_q;
    logic [BAND_W-1:0] nb_q;
    logic [BAND_W-1:0] band_cnt;

    // Phase transitions and counter updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            seed_idx <= 1'b0;
            band_cnt <= '0;
            pix_cnt  <= '0;
            dump_cnt <= '0;
            np_q     <= '0;
            nb_q     <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    np_q     <= cfg_pixels;
                    nb_q     <= cfg_bands;
                    seed_idx <= 1'b0;
                    phase    <= PH_SEED;
                end
                PH_SEED: if (!in_empty) begin
                    seed_idx <= 1'b1;
                    if (seed_idx) begin
                        band_cnt <= '0;
                        pix_cnt  <= '0;
                        phase    <= PH_BAND;
                    end
                end
                PH_BAND: if (!in_empty) begin
                    band_cnt <= band_cnt + BAND_W'(1);
                    if (band_cnt == nb_q - BAND_W'(1))
                        phase <= PH_CMP;
                end
                PH_CMP: begin
                    if (pix_cnt == np_q - PIX_W'(1)) begin
                        dump_cnt <= '0;
                        phase    <= PH_DUMP;
                    end else begin
                        pix_cnt  <= pix_cnt + PIX_W'(1);
                        band_cnt <= '0;
                        phase    <= PH_BAND;
                    end
                end
                PH_DUMP: begin
                    dump_cnt <= dump_cnt + RSEL_W'(1);
                    if (dump_cnt == RSEL_W'(NRES - 1))
                        phase <= PH_FIN;
                end
                PH_FIN:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R5
    band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BAND && in_empty) |=> $stable(band_cnt));
    // R6
    cmp_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CMP) |-> (band_cnt == nb_q));
    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(np_q) && $stable(nb_q)));
endmodule

// File: rtl/seq_refill_ctl.sv
// Half-capacity watermark requester. Issues a one-cycle request while the
// pass is feeding and occupancy is at or below half, then waits for the
// transfer engine's completion before it can request again.
module seq_refill_ctl #(
    parameter int DEPTH = 1024,
    parameter int LVL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             feeding,
    input  logic [LVL_W-1:0] in_level,
    input  logic             refill_done,
    output logic             refill_req,
    output logic [LVL_W-1:0] refill_len
);
    localparam int HALF = DEPTH / 2;

    logic armed;

    assign refill_len = LVL_W'(HALF);
    assign refill_req = armed && feeding && (in_level <= LVL_W'(HALF));

    // Track whether a new request may be issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b1;
        else if (refill_req)
            armed <= 1'b0;
        else if (refill_done)
            armed <= 1'b1;
    end

    // R8
    single_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refill_req |=> !refill_req);
endmodule

// File: rtl/seq_strobe_map.sv
// Decodes the current phase into the FIFO pop, generator, array and output
// strobes. Purely combinational; data paths pass straight through.
module seq_strobe_map
    import hsi_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PIX_W  = 20,
    parameter int RSEL_W = 6
) (
    input  seq_phase_t        phase,
    input  logic              seed_idx,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic [RSEL_W-1:0] dump_cnt,
    input  logic              in_empty,
    input  logic [DATA_W-1:0] in_data,
    input  logic [PIX_W-1:0]  res_word,
    output logic              in_rd_en,
    output logic              seed_load,
    output logic              seed_sel,
    output logic [DATA_W-1:0] seed_data,
    output logic              gen_advance,
    output logic              gen_restore,
    output logic              band_valid,
    output logic [DATA_W-1:0] band_data,
    output logic              px_end,
    output logic [PIX_W-1:0]  px_index,
    output logic [RSEL_W-1:0] res_sel,
    output logic              out_wr,
    output logic [PIX_W-1:0]  out_data,
    output logic              feeding,
    output logic              fin
);
    // Strobe decode from the phase and FIFO state.
    always_comb begin
        seed_load   = (phase == PH_SEED) && !in_empty;
        band_valid  = (phase == PH_BAND) && !in_empty;
        gen_advance = band_valid;
        in_rd_en    = seed_load || band_valid;
        px_end      = (phase == PH_CMP);
        gen_restore = px_end;
        out_wr      = (phase == PH_DUMP);
        fin         = (phase == PH_FIN);
        feeding     = (phase == PH_SEED) || (phase == PH_BAND) || (phase == PH_CMP);
    end

    assign seed_sel  = seed_idx;
    assign seed_data = in_data;
    assign band_data = in_data;
    assign px_index  = pix_cnt;
    assign res_sel   = dump_cnt;
    assign out_data  = res_word;
endmodule

// File: rtl/hsi_feed_sequencer.sv
// Top of the pixel stream sequencer. Ties the phase machine, the refill
// watermark unit and the strobe decode together. Assumes the output FIFO
// always has room for a full result walk.
module hsi_feed_sequencer
    import hsi_seq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024,
    parameter int PIX_W  = 20,
    parameter int BAND_W = 10,
    parameter int NSKEW  = 20,
    localparam int LVL_W  = $clog2(DEPTH) + 1,
    localparam int NRES   = 2 * NSKEW,
    localparam int RSEL_W = (NRES > 1) ? $clog2(NRES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PIX_W-1:0]  cfg_pixels,
    input  logic [BAND_W-1:0] cfg_bands,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_empty,
    input  logic [LVL_W-1:0]  in_level,
    output logic              in_rd_en,
    output logic              refill_req,
    output logic [LVL_W-1:0]  refill_len,
    input  logic              refill_done,
    output logic              seed_load,
    output logic              seed_sel,
    output logic [DATA_W-1:0] seed_data,
    output logic              gen_advance,
    output logic              gen_restore,
    output logic              band_valid,
    output logic [DATA_W-1:0] band_data,
    output logic              px_end,
    output logic [PIX_W-1:0]  px_index,
    output logic [RSEL_W-1:0] res_sel,
    input  logic [PIX_W-1:0]  res_word,
    output logic              out_wr,
    output logic [PIX_W-1:0]  out_data,
    output logic              done
);
    seq_phase_t        phase;
    logic              seed_idx;
    logic [PIX_W-1:0]  pix_cnt;
    logic [RSEL_W-1:0] dump_cnt;
    logic              feeding;
    logic              fin;

    seq_phase_ctl #(
        .PIX_W(PIX_W), .BAND_W(BAND_W), .NRES(NRES), .RSEL_W(RSEL_W)
    ) i_phase (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_pixels(cfg_pixels), .cfg_bands(cfg_bands), .in_empty(in_empty),
        .phase(phase), .seed_idx(seed_idx), .pix_cnt(pix_cnt), .dump_cnt(dump_cnt)
    );

    seq_refill_ctl #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_refill (
        .clk(clk), .rst_n(rst_n), .feeding(feeding), .in_level(in_level),
        .refill_done(refill_done), .refill_req(refill_req), .refill_len(refill_len)
    );

    seq_strobe_map #(.DATA_W(DATA_W), .PIX_W(PIX_W), .RSEL_W(RSEL_W)) i_map (
        .phase(phase), .seed_idx(seed_idx), .pix_cnt(pix_cnt), .dump_cnt(dump_cnt),
        .in_empty(in_empty), .in_data(in_data), .res_word(res_word),
        .in_rd_en(in_rd_en), .seed_load(seed_load), .seed_sel(seed_sel),
        .seed_data(seed_data), .gen_advance(gen_advance), .gen_restore(gen_restore),
        .band_valid(band_valid), .band_data(band_data), .px_end(px_end),
        .px_index(px_index), .res_sel(res_sel), .out_wr(out_wr), .out_data(out_data),
        .feeding(feeding), .fin(fin)
    );

    assign done = fin;

    // R10
    done_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_wr));
    // R6
    cmp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        px_end |=> !px_end);
    // R4
    band_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        band_valid |-> (in_rd_en && gen_advance && !seed_load));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !(in_rd_en || px_end || out_wr || done));
endmodule

// File: tb/test_hsi_feed_sequencer.sv
// Behavioural reference model plus FIFO and transfer-engine stand-ins.
module test_hsi_feed_sequencer;
    localparam int DATA_W = 16, DEPTH = 16, PIX_W = 8, BAND_W = 6, NSKEW = 3;
    localparam int LVL_W = $clog2(DEPTH) + 1;
    localparam int NRES = 2 * NSKEW;
    localparam int RSEL_W = $clog2(NRES);
    localparam int HALF = DEPTH / 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, start = 1'b0, refill_done = 1'b0;
    logic [PIX_W-1:0] cfg_pixels = '0;
    logic [BAND_W-1:0] cfg_bands = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_empty = 1'b1;
    logic [LVL_W-1:0] in_level = '0;
    logic in_rd_en, refill_req, seed_load, seed_sel, gen_advance, gen_restore;
    logic band_valid, px_end, out_wr, done;
    logic [LVL_W-1:0] refill_len;
    logic [DATA_W-1:0] seed_data, band_data;
    logic [PIX_W-1:0] px_index, res_word, out_data;
    logic [RSEL_W-1:0] res_sel;

    assign res_word = PIX_W'(res_sel * 5 + 1);

    hsi_feed_sequencer #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PIX_W(PIX_W),
        .BAND_W(BAND_W), .NSKEW(NSKEW)) i_hsi_feed_sequencer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_pixels(cfg_pixels),
        .cfg_bands(cfg_bands), .in_data(in_data), .in_empty(in_empty),
        .in_level(in_level), .in_rd_en(in_rd_en), .refill_req(refill_req),
        .refill_len(refill_len), .refill_done(refill_done), .seed_load(seed_load),
        .seed_sel(seed_sel), .seed_data(seed_data), .gen_advance(gen_advance),
        .gen_restore(gen_restore), .band_valid(band_valid), .band_data(band_data),
        .px_end(px_end), .px_index(px_index), .res_sel(res_sel), .res_word(res_word),
        .out_wr(out_wr), .out_data(out_data), .done(done));

    int total = 0, bad = 0, cyc = 0, done_seen = 0;
    bit seen_edge = 0, finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
        end
    endtask

    // FIFO stand-in and feeder state
    logic [DATA_W-1:0] q[$];
    int src_left = 0, fill_left = 0, tick = 0;
    logic [DATA_W-1:0] src_val = 16'h0100;
    bit pop_pend = 0, req_pend = 0, fill_active = 0, slow = 0;

    function automatic void refresh();
        in_empty = (q.size() == 0);
        in_data  = (q.size() != 0) ? q[0] : '0;
        in_level = LVL_W'(q.size());
    endfunction

    function automatic void push_one();
        q.push_back(src_val);
        src_val = src_val + 1'b1;
        src_left--;
    endfunction

    // FIFO pops and transfer-engine responses, applied just after each edge.
    always @(posedge clk) begin
        #1;
        cyc++;
        if (pop_pend && q.size() != 0) void'(q.pop_front());
        pop_pend = 0;
        refill_done = 1'b0;
        if (fill_active && fill_left == 0) begin
            refill_done = 1'b1;
            fill_active = 0;
        end
        if (req_pend) begin
            fill_left = (src_left < HALF) ? src_left : HALF;
            fill_active = 1;
            req_pend = 0;
        end
        tick++;
        if (fill_active && fill_left > 0 && (!slow || tick % 3 == 0)) begin
            push_one();
            fill_left--;
        end
        refresh();
    end

    // Reference model state
    int m_ph = 0, m_seeds = 0, m_band = 0, m_px = 0, m_dump = 0, m_np = 0, m_nb = 0;
    bit m_armed = 1;
    logic [DATA_W-1:0] m_val = 16'h0100;

    // Cycle-by-cycle comparison, then model advance for the coming edge.
    always @(negedge clk) begin
        bit e_rd, e_seed, e_band, e_cmp, e_wr, e_done, e_req;
        if (!rst_n) begin
            m_ph = 0; m_armed = 1;
            if (seen_edge) begin
                // R1 strobes quiet in reset
                chk(!(in_rd_en | seed_load | gen_advance | gen_restore | band_valid |
                      px_end | out_wr | refill_req | done), "R1",
                    {in_rd_en, seed_load, band_valid, px_end, out_wr, refill_req, done}, 0);
            end
        end else begin
            e_seed = (m_ph == 1) && !in_empty;
            e_band = (m_ph == 2) && !in_empty;
            e_rd   = e_seed || e_band;
            e_cmp  = (m_ph == 3);
            e_wr   = (m_ph == 4);
            e_done = (m_ph == 5);
            e_req  = m_armed && (m_ph >= 1 && m_ph <= 3) && (int'(in_level) <= HALF);
            chk(seed_load == e_seed, "R3 seed_load", seed_load, e_seed);
            if (e_seed) begin
                chk(seed_sel == (2 - m_seeds), "R3 seed_sel", seed_sel, 2 - m_seeds);
                chk(seed_data == m_val, "R3 seed_data", seed_data, m_val);
            end
            chk(band_valid == e_band, "R4/R5 band_valid", band_valid, e_band);
            chk(gen_advance == e_band, "R4/R5 gen_advance", gen_advance, e_band);
            chk(in_rd_en == e_rd, "R4/R5 in_rd_en", in_rd_en, e_rd);
            if (e_band) chk(band_data == m_val, "R4 band_data", band_data, m_val);
            chk(px_end == e_cmp, "R6 px_end", px_end, e_cmp);
            chk(gen_restore == e_cmp, "R6 gen_restore", gen_restore, e_cmp);
            if (e_cmp) chk(int'(px_index) == m_px, "R6 px_index", px_index, m_px);
            chk(out_wr == e_wr, "R9 out_wr", out_wr, e_wr);
            if (e_wr) begin
                chk(int'(res_sel) == m_dump, "R9 res_sel", res_sel, m_dump);
                chk(int'(out_data) == m_dump * 5 + 1, "R9 out_data", out_data, m_dump * 5 + 1);
            end
            chk(done == e_done, "R10 done", done, e_done);
            chk(refill_req == e_req, "R7/R8 refill_req", refill_req, e_req);
            chk(int'(refill_len) == HALF, "R7 refill_len", refill_len, HALF);

            if (e_rd) m_val = m_val + 1'b1;
            if (e_req) m_armed = 0;
            else if (refill_done) m_armed = 1;
            case (m_ph)
                0: if (start) begin m_np = cfg_pixels; m_nb = cfg_bands; m_seeds = 2; m_ph = 1; end
                1: if (e_seed) begin m_seeds--; if (m_seeds == 0) begin m_ph = 2; m_band = 0; m_px = 0; end end
                2: if (e_band) begin m_band++; if (m_band == m_nb) m_ph = 3; end
                3: if (m_px == m_np - 1) begin m_ph = 4; m_dump = 0; end
                   else begin m_px++; m_band = 0; m_ph = 2; end
                4: begin m_dump++; if (m_dump == NRES) m_ph = 5; end
                default: m_ph = 0;
            endcase
            if (done) done_seen++;
            if (refill_req) req_pend = 1;
        end
        pop_pend = in_rd_en;
    end

    always @(posedge clk) seen_edge <= 1;

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        if (cyc > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog at cycle %0d: actual=hung expected=finished", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic run_pass(input int np, input int nb, input int pre, input bit slw,
                            input bit poke);
        int target;
        target = done_seen + 1;
        @(posedge clk); #1;
        slow = slw;
        src_left = 2 + np * nb;
        for (int i = 0; i < pre && src_left > 0; i++) push_one();
        refresh();
        repeat (3) @(posedge clk);
        #1;
        start = 1'b1; cfg_pixels = PIX_W'(np); cfg_bands = BAND_W'(nb);
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            // R2 mid-pass start and configuration change must be ignored
            repeat (4) @(posedge clk);
            #1;
            start = 1'b1; cfg_pixels = PIX_W'(np + 3); cfg_bands = BAND_W'(nb + 2);
            @(posedge clk); #1;
            start = 1'b0;
        end
        while (done_seen < target) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        run_pass(3, 4, 14, 0, 0);   // plentiful data
        run_pass(2, 5, 0, 0, 0);    // empty at start: R4 waits, R7 fires in seed phase
        run_pass(4, 3, 4, 1, 1);    // slow feeder stalls: R5, R2 poke
        run_pass(1, 1, 3, 0, 0);    // smallest pass
        run_pass(5, 6, 16, 0, 0);   // watermark crossings in all phases
        // R10 pass count reached
        chk(done_seen == 5, "R10 pass count", done_seen, 5);
        // R1 reset mid-idle then quiet
        #1 rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        run_pass(2, 2, 6, 0, 0);
        chk(done_seen == 6, "R10 restart after reset", done_seen, 6);
        chk(q.size() == 0, "R4 all words consumed", q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule